// File: doc/BRIEF.md
# Debug Run-Control Unit

This block sits between the register side of a debug module and a simple in-order core. It takes resume, halt and single-step commands and drives one issue-enable line into the core. It counts the instructions that are issued but not yet retired, and it reports a two-bit status that the debugger polls. A halt is complete only when that status reads stopped.

A halt does not take effect at once. The unit stops issuing first. It then reports a separate "stopping" status until every in-flight instruction has retired. Only then does it report stopped.

A debugger write to registers, the program counter or memory is signalled by a one-cycle strobe, which marks the core state as modified. The next resume or step then requests a pipeline flush and waits for the acknowledge before any instruction issues. If nothing was modified, execution resumes with no flush. A write made while the core is running sets the same flag, but the unit makes no promise about the effect of that write on the running program.

Top module: `dbg_run_ctrl`

## Requirements
- R1: Command encoding on `cmd`: 00 none, 01 resume, 10 halt, 11 step. A resume in the stopped state with no pending modification makes `issue_en` high after the next clock edge, with status running. A resume while running is ignored.
- R2: A step raises `issue_en` until exactly one instruction is accepted (`issue_fire` while `issue_en` is high). At the following edge `issue_en` falls, and any later `issue_fire` is not counted.
- R3: A halt or step received while running, and the end of a step, all enter the stopping status (01) with `issue_en` low. Status stays 01 while any instruction is in flight.
- R4: Status becomes stopped (10) on the clock edge after the in-flight count reaches zero, and never while the count is non-zero.
- R5: A command received in the stopping status is held, with the latest one winning. It is carried out in the first cycle after stopped is reached.
- R6: Status encoding is 00 running (this includes flush and step issue), 01 stopping and 10 stopped. The value 11 never appears.
- R7: After a `state_wr` strobe, the next resume or step raises `flush_req` with `issue_en` low. `flush_req` stays high until `flush_ack`, after which the command proceeds. The acknowledge clears the modified mark. With no strobe, no flush is requested.
- R8: After reset the status is stopped (10), `issue_en` and `flush_req` are low, and no modification is marked.
- R9: Commands received during a flush are discarded. During step issue, a halt cancels the step and enters stopping, while resume and step are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Command code, sampled every cycle (00 none) |
| state_wr | input | 1 | Debugger modified architectural state |
| issue_fire | input | 1 | Core accepted an instruction this cycle |
| retire | input | 1 | One instruction retired this cycle |
| flush_ack | input | 1 | Pipeline flush completed |
| issue_en | output | 1 | Core may issue instructions |
| flush_req | output | 1 | Request a pipeline flush |
| status | output | 2 | Run status: 00 running, 01 stopping, 10 stopped |

## Verification
The bench builds the unit with its default in-flight limit of four. This lets two outstanding instructions drain one retire at a time, so the stopping status can be observed across several cycles before stopped appears. A queued scoreboard covers a command captured while draining, a step whose extra accept pulse must not count, and flushes both with and without a prior state write. It also covers commands sent during a flush and a halt sent during step issue.

// File: rtl/dbg_rc_pkg.sv
// Shared encodings for the debug run-control unit.
package dbg_rc_pkg;

    // Command codes presented on the cmd port.
    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_START = 2'b01,
        CMD_STOP  = 2'b10,
        CMD_STEP  = 2'b11
    } rc_cmd_e;

    // Internal control states.
    typedef enum logic [2:0] {
        S_RUN,
        S_DRAIN,
        S_HALT,
        S_FLUSH,
        S_STEP
    } rc_state_e;

    // Status codes seen by the debugger.
    localparam logic [1:0] ST_RUNNING  = 2'b00;
    localparam logic [1:0] ST_STOPPING = 2'b01;
    localparam logic [1:0] ST_STOPPED  = 2'b10;

endpackage

// File: rtl/rc_pending_cmd.sv
// Holds one command received while the pipeline drains.
// Assumes: the owner asserts consume in the cycle the command is acted on.
// A new capture overwrites an older one (the latest wins).
module rc_pending_cmd
    import dbg_rc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    capture,
    input  rc_cmd_e cmd_in,
    input  logic    consume,
    output logic    pend_valid,
    output rc_cmd_e pend_cmd
);

    // Capture a non-empty command, or drop it once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_cmd   <= CMD_NONE;
        end else if (capture && cmd_in != CMD_NONE) begin
            pend_valid <= 1'b1;
            pend_cmd   <= cmd_in;
        end else if (consume) begin
            pend_valid <= 1'b0;
            pend_cmd   <= CMD_NONE;
        end
    end

endmodule

// File: rtl/rc_inflight.sv
// Counts instructions that are issued but not yet retired.
// Assumes: a retire never arrives for an instruction that was not counted.
// Saturates at MAX and never goes below zero.
module rc_inflight #(
    parameter int MAX = 4,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          empty
);

    logic do_inc;
    logic do_dec;

    // Guard against running past either end of the counter.
    always_comb begin
        do_inc = inc && (count != CW'(MAX));
        do_dec = dec && (count != '0);
    end

    // Apply the net change of issue and retire for this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (do_inc && !do_dec) begin
            count <= count + 1'b1;
        end else if (do_dec && !do_inc) begin
            count <= count - 1'b1;
        end
    end

    // Flag an empty pipeline.
    assign empty = (count == '0);

endmodule

// File: rtl/rc_dirty.sv
// Records that the debugger changed architectural state.
// Assumes: a mark in the same cycle as a clear wins, so a fresh write is kept.
module rc_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    input  logic clear,
    output logic dirty
);

    // Set on a write strobe, cleared by a completed flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (mark) begin
            dirty <= 1'b1;
        end else if (clear) begin
            dirty <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_run_ctrl.sv
// Debug run-control unit: sequences resume, halt and single-step, and
// reports a stopping status until the pipeline drains.
// Assumes: issue_fire is meaningful only while issue_en is high, and retire
// pulses once per accepted instruction.
module dbg_run_ctrl
    import dbg_rc_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd,
    input  logic       state_wr,
    input  logic       issue_fire,
    input  logic       retire,
    input  logic       flush_ack,
    output logic       issue_en,
    output logic       flush_req,
    output logic [1:0] status
);

    rc_state_e        state_q, state_d;
    logic             resume_step_q, resume_step_d;
    rc_cmd_e          cmd_now;
    rc_cmd_e          halt_cmd;
    logic             pend_valid;
    rc_cmd_e          pend_cmd;
    logic [CNT_W-1:0] inflight_cnt;
    logic             pipe_empty;
    logic             dirty;
    logic             step_phase;

    assign cmd_now    = rc_cmd_e'(cmd);
    assign step_phase = (state_q == S_STEP);

    rc_pending_cmd u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (state_q == S_DRAIN),
        .cmd_in     (cmd_now),
        .consume    (state_q == S_HALT),
        .pend_valid (pend_valid),
        .pend_cmd   (pend_cmd)
    );

    rc_inflight #(.MAX(MAX_INFLIGHT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue_en && issue_fire),
        .dec   (retire),
        .count (inflight_cnt),
        .empty (pipe_empty)
    );

    rc_dirty u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .mark  (state_wr),
        .clear (state_q == S_FLUSH && flush_ack),
        .dirty (dirty)
    );

    // Command seen in the halted state: a live one beats a held one.
    always_comb begin
        if (cmd_now != CMD_NONE) begin
            halt_cmd = cmd_now;
        end else if (pend_valid) begin
            halt_cmd = pend_cmd;
        end else begin
            halt_cmd = CMD_NONE;
        end
    end

    // Next-state logic of the run-control sequencer.
    always_comb begin
        state_d       = state_q;
        resume_step_d = resume_step_q;
        unique case (state_q)
            S_RUN: begin
                if (cmd_now == CMD_STOP || cmd_now == CMD_STEP) begin
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (pipe_empty) begin
                    state_d = S_HALT;
                end
            end
            S_HALT: begin
                if (halt_cmd == CMD_START) begin
                    state_d       = dirty ? S_FLUSH : S_RUN;
                    resume_step_d = 1'b0;
                end else if (halt_cmd == CMD_STEP) begin
                    state_d       = dirty ? S_FLUSH : S_STEP;
                    resume_step_d = 1'b1;
                end
            end
            S_FLUSH: begin
                if (flush_ack) begin
                    state_d = resume_step_q ? S_STEP : S_RUN;
                end
            end
            S_STEP: begin
                if (cmd_now == CMD_STOP || issue_fire) begin
                    state_d = S_DRAIN;
                end
            end
            default: state_d = S_HALT;
        endcase
    end

    // State registers; reset lands in the halted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= S_HALT;
            resume_step_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            resume_step_q <= resume_step_d;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        issue_en  = (state_q == S_RUN) || (state_q == S_STEP);
        flush_req = (state_q == S_FLUSH);
        unique case (state_q)
            S_DRAIN: status = ST_STOPPING;
            S_HALT:  status = ST_STOPPED;
            default: status = ST_RUNNING;
        endcase
    end

endmodule

// File: rtl/dbg_run_ctrl_chk.sv
// Property checker for the run-control unit, bound into every instance.
module dbg_run_ctrl_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    status,
    input logic          issue_en,
    input logic          issue_fire,
    input logic          flush_req,
    input logic          flush_ack,
    input logic [CW-1:0] inflight_cnt,
    input logic          step_phase
);

    p_status_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    p_stopping_no_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b01 |-> !issue_en);

    p_stopped_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b10 |-> inflight_cnt == '0);

    p_flush_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req);

    p_flush_no_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !issue_en);

    p_step_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_phase && issue_fire |=> !issue_en);

endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk #(.CW(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .status       (status),
    .issue_en     (issue_en),
    .issue_fire   (issue_fire),
    .flush_req    (flush_req),
    .flush_ack    (flush_ack),
    .inflight_cnt (inflight_cnt),
    .step_phase   (step_phase)
);

// File: tb/tb_dbg_run_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_run_ctrl;

    typedef struct {
        logic [1:0] st;
        logic       ie;
        logic       fr;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       state_wr = 1'b0;
    logic       issue_fire = 1'b0;
    logic       retire = 1'b0;
    logic       flush_ack = 1'b0;
    logic       issue_en;
    logic       flush_req;
    logic [1:0] status;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    localparam logic [1:0] C_NONE = 2'b00, C_START = 2'b01, C_STOP = 2'b10, C_STEP = 2'b11;
    localparam logic [1:0] RUNNING = 2'b00, STOPPING = 2'b01, STOPPED = 2'b10;

    always #4 clk = ~clk;

    dbg_run_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .state_wr   (state_wr),
        .issue_fire (issue_fire),
        .retire     (retire),
        .flush_ack  (flush_ack),
        .issue_en   (issue_en),
        .flush_req  (flush_req),
        .status     (status)
    );

    // Drive one cycle of stimulus, then return the pulses to idle.
    task automatic cyc(input logic [1:0] c, input logic f, input logic r,
                       input logic w, input logic a);
        cmd = c; issue_fire = f; retire = r; state_wr = w; flush_ack = a;
        @(posedge clk); #1;
        cmd = C_NONE; issue_fire = 1'b0; retire = 1'b0; state_wr = 1'b0; flush_ack = 1'b0;
    endtask

    // Queue an expected output set for the monitor.
    task automatic expect_out(input logic [1:0] st, input logic ie, input logic fr,
                              input string tag);
        exp_t e;
        e.st = st; e.ie = ie; e.fr = fr; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (status !== e.st || issue_en !== e.ie || flush_req !== e.fr) begin
                n_bad++;
                $display("FAIL %s: got st=%b ie=%b fr=%b, exp st=%b ie=%b fr=%b",
                         e.tag, status, issue_en, flush_req, e.st, e.ie, e.fr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out(STOPPED, 0, 0, "R8 reset state");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPED, 0, 0, "R8 idle after reset");

        // Resume clean, issue two instructions, ignored resume.
        cyc(C_START, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R1 resume");
        cyc(C_NONE, 1, 0, 0, 0);
        cyc(C_NONE, 1, 0, 0, 0);
        cyc(C_START, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R1 resume while running ignored");

        // Halt with two in flight.
        cyc(C_STOP, 0, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R3 halt enters stopping");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R3 stopping held with work");
        cyc(C_STEP, 0, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R5 step captured");
        cyc(C_NONE, 0, 1, 0, 0);
        expect_out(STOPPING, 0, 0, "R4 one still in flight");
        cyc(C_NONE, 0, 1, 0, 0);
        expect_out(STOPPING, 0, 0, "R4 count just reached zero");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPED, 0, 0, "R4 stopped after drain");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R5 held step carried out");

        // Single step.
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R2 step waits for accept");
        cyc(C_NONE, 1, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R2 issue off after one");
        cyc(C_NONE, 1, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R2 extra accept not counted");
        cyc(C_NONE, 0, 1, 0, 0);
        expect_out(STOPPING, 0, 0, "R3 step end stopping");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPED, 0, 0, "R2 stopped after extra accept ignored");

        // Modified state then resume: flush.
        cyc(C_NONE, 0, 0, 1, 0);
        expect_out(STOPPED, 0, 0, "R7 write keeps stopped");
        cyc(C_START, 0, 0, 0, 0);
        expect_out(RUNNING, 0, 1, "R7 flush requested R6");
        cyc(C_STOP, 0, 0, 0, 0);
        expect_out(RUNNING, 0, 1, "R9 halt during flush discarded");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(RUNNING, 0, 1, "R7 flush held without ack");
        cyc(C_NONE, 0, 0, 0, 1);
        expect_out(RUNNING, 1, 0, "R7 resume after ack");

        // Clean halt and resume: no flush.
        cyc(C_STOP, 0, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R3 halt empty pipe");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPED, 0, 0, "R4 stopped empty pipe");
        cyc(C_START, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R7 clean resume no flush");

        // Step while running halts; modified then step flushes; halt cancels step.
        cyc(C_STEP, 0, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R3 step while running");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPED, 0, 0, "R4 stopped again");
        cyc(C_NONE, 0, 0, 1, 0);
        cyc(C_STEP, 0, 0, 0, 0);
        expect_out(RUNNING, 0, 1, "R7 step flush");
        cyc(C_NONE, 0, 0, 0, 1);
        expect_out(RUNNING, 1, 0, "R7 step after ack");
        cyc(C_START, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R9 resume in step discarded");
        cyc(C_STOP, 0, 0, 0, 0);
        expect_out(STOPPING, 0, 0, "R9 halt cancels step");
        cyc(C_NONE, 0, 0, 0, 0);
        expect_out(STOPPED, 0, 0, "R9 stopped after cancel");
        cyc(C_START, 0, 0, 0, 0);
        expect_out(RUNNING, 1, 0, "R7 flag cleared by ack");

        @(negedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule